// File: doc/BRIEF.md
# Eight-Output Addressable Latch Bank

This block keeps eight single-bit storage cells that drive an 8-bit output vector. Each cycle, a 3-bit address picks one cell and a one-bit data input supplies its new value. Two active-low controls, a write enable and a clear, select one of four modes:

- **Write:** the addressed cell is loaded and every other cell keeps its value.
- **Demultiplex:** the data bit is routed to the addressed output and all other outputs are forced low.
- **Hold:** every cell keeps its value and the address and data are ignored.
- **Clear:** all cells are emptied.

Every mode takes effect at the rising clock edge, and the outputs come straight from flip-flops. The block fits where a narrow serial-style control path must set, strobe or clear individual enable lines one at a time. An example is a controller that drives eight load switches, indicator lines or chip selects from a 3-bit address and a single data wire.

Top module: `addr_latch_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs become 0 on that edge, whatever the other inputs are.
- R2: With `wr_en_n`=0 and `clr_n`=1 (write mode), output bit `addr` takes `din` at the edge and the seven other bits keep their values.
- R3: With `wr_en_n`=0 and `clr_n`=0 (demultiplex mode), output bit `addr` takes `din` at the edge and the seven other bits become 0.
- R4: With `wr_en_n`=1 and `clr_n`=1 (hold mode), no output bit changes, whatever values `addr` and `din` take.
- R5: With `wr_en_n`=1 and `clr_n`=0 (clear mode), all eight output bits become 0 at the edge.
- R6: Address value k (0 to 7, unsigned binary) selects output bit `q[k]`.
- R7: Outputs are registered. An input change has no effect on `q` until the next rising edge, and its result is visible right after that edge.
- R8: Entering hold mode straight after demultiplex mode keeps the single-bit pattern that demultiplex mode left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all outputs |
| addr | input | 3 | Selects which output bit the data bit goes to |
| din | input | 1 | Data bit written to the selected output |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Registered output vector, one bit per storage cell |

## Verification
A vector table first builds up a multi-bit pattern with write mode. It then sweeps hold mode with changing address and data, which tells a true hold apart from a stray write. Next, demultiplex mode is entered over a populated vector, which separates forcing the other bits low from preserving them as write mode does. Clear, and writes that follow a clear, show that the cells recover. Directed tests then walk every address in demultiplex mode to pin the bit ordering, probe the output between edges to confirm the one-cycle register, and assert reset over a pending write.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode code is {wr_en_n, clr_n}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } lat_mode_e;

  function automatic lat_mode_e decode_mode(input logic wr_en_n, input logic clr_n);
    return lat_mode_e'({wr_en_n, clr_n});
  endfunction

endpackage

// File: rtl/addr_latch_decode.sv
module addr_latch_decode #(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_BITS-1:0] sel
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/addr_latch_next.sv
module addr_latch_next
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  lat_mode_e             mode,
  input  logic                  din,
  input  logic [NUM_BITS-1:0]   sel,
  input  logic [NUM_BITS-1:0]   cur,
  output logic [NUM_BITS-1:0]   nxt
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    always_comb begin
      unique case (mode)
        MODE_WRITE: nxt[i] = sel[i] ? din : cur[i];
        MODE_DEMUX: nxt[i] = sel[i] & din;
        MODE_CLEAR: nxt[i] = 1'b0;
        default:    nxt[i] = cur[i];
      endcase
    end
  end

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  input  logic                wr_en_n,
  input  logic                clr_n,
  output logic [NUM_BITS-1:0] q
);

  lat_mode_e             mode;
  logic [NUM_BITS-1:0]   sel;
  logic [NUM_BITS-1:0]   nxt;

  assign mode = decode_mode(wr_en_n, clr_n);

  addr_latch_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  addr_latch_next #(.NUM_BITS(NUM_BITS)) u_next (
    .mode (mode),
    .din  (din),
    .sel  (sel),
    .cur  (q),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                din,
  input logic                wr_en_n,
  input logic                clr_n,
  input logic [NUM_BITS-1:0] q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0);

  // R2
  write_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && clr_n) |=> q[$past(addr)] == $past(din));

  // R3
  demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && !clr_n) |=> ($onehot0(q) && q[$past(addr)] == $past(din)));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n && clr_n) |=> $stable(q));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n && !clr_n) |=> q == '0);

endmodule

bind addr_latch_bank addr_latch_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .din     (din),
  .wr_en_n (wr_en_n),
  .clr_n   (clr_n),
  .q       (q)
);

// File: tb/addr_latch_bank_tb.sv
`timescale 1ns/1ps
module addr_latch_bank_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic       wr_en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [7:0] q;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  addr_latch_bank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
  );

  // {wr_en_n, clr_n, addr[2:0], din, expected q[7:0]}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h01},
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h81},
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h89},
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h88},
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h88},
    {1'b1, 1'b1, 3'd2, 1'b0, 8'h88},
    {1'b0, 1'b0, 3'd5, 1'b1, 8'h20},
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h20},
    {1'b0, 1'b0, 3'd6, 1'b0, 8'h00},
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h02},
    {1'b0, 1'b1, 3'd2, 1'b1, 8'h06},
    {1'b1, 1'b0, 3'd4, 1'b1, 8'h00},
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h10},
    {1'b0, 1'b0, 3'd0, 1'b1, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic we_n, input logic cl_n);
    if (!we_n && cl_n)  return "R2";
    if (!we_n && !cl_n) return "R3 R8";
    if (we_n && cl_n)   return "R4 R8";
    return "R5";
  endfunction

  task automatic step(input logic we_n, input logic cl_n, input logic [2:0] a, input logic d);
    @(negedge clk);
    wr_en_n = we_n; clr_n = cl_n; addr = a; din = d;
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: q=%h expected finish", q);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", q, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      @(negedge clk);
      check(req_of(VEC[i][13], VEC[i][12]), q, VEC[i][7:0]);
    end

    // R6: every address in demultiplex mode
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b0, 3'(k), 1'b1);
      @(negedge clk);
      check("R6 decode", q, 8'(1) << k);
    end

    // R7: no change before the edge, change right after it
    step(1'b1, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    wr_en_n = 1'b0; clr_n = 1'b1; addr = 3'd6; din = 1'b1;
    #1;
    check("R7 before edge", q, 8'h00);
    @(posedge clk); #0.5;
    check("R7 after edge", q, 8'h40);

    // R4: address/data toggling in hold mode
    step(1'b1, 1'b1, 3'd6, 1'b0);
    step(1'b1, 1'b1, 3'd3, 1'b1);
    @(negedge clk);
    check("R4 hold toggling", q, 8'h40);

    // R1: reset overrides a pending write
    step(1'b0, 1'b1, 3'd2, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset over write", q, 8'h00);
    rst = 1'b0;
    wr_en_n = 1'b1; clr_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", q, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule